// File: doc/BRIEF.md
# Dispatch-Group Store/Load Overlap Detector

This block remembers the memory footprints of the stores issued so far in the current dispatch group. When a later load in the same group arrives, the block raises a flag if the load's footprint lands on or overlaps any remembered store. A neighbouring group tracker turns that flag into a request to insert a no-op.

A footprint has three parts: a base identifier, a signed byte offset from that base, and a byte count. Two footprints are compared only when their base identifiers are equal. The block does not compute real addresses, and it never reports overlap between different bases. The store table holds a fixed number of entries, four by default. A small fill-level state machine runs the table: TBL_EMPTY, TBL_FILLING and TBL_FULL. The transitions are:
- record: TBL_EMPTY to TBL_FILLING, or to TBL_FULL when the depth is 1.
- fill: TBL_FILLING to TBL_FULL when the last slot is written.
- clear: any state to TBL_EMPTY.
- clear-and-record: any state to TBL_FILLING, or to TBL_FULL when the depth is 1.

The group-clear strobe ends a group. The overlap flag is combinational from the load query and the registered table.

Top module: `grp_mem_overlap`

## Requirements
- R1: The table records at most DEPTH (default 4) stores per group. A store that arrives while the table is full is dropped, so a load that touches only that store gives no hit.
- R2: A store presented with `st_has_info` = 0 is not recorded.
- R3: A load with the same base and the same offset as a recorded store hits, even when either size is zero.
- R4: With equal bases and a store offset below the load offset, the load hits if and only if store offset + store size > load offset.
- R5: With equal bases and a store offset at or above the load offset, the load hits if and only if load offset + load size > store offset.
- R6: A load whose base differs from the base of every recorded store never hits.
- R7: `overlap_hit` is 1 only when `ld_valid` = 1, `ld_has_info` = 1 and at least one store is recorded.
- R8: After a cycle with `grp_clear` = 1 and no store, the table is empty.
- R9: A store together with `grp_clear` in the same cycle clears the table first. The store then becomes the only entry of the new group.
- R10: `overlap_hit` follows the query in the same cycle. A store is visible to queries only from the cycle after it is recorded.
- R11: Offsets are signed 64-bit and sizes are unsigned 16-bit. Offset + size is formed at 65 bits, so the comparison does not wrap near the ends of the offset range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the table |
| grp_clear | input | 1 | Ends the current dispatch group |
| st_valid | input | 1 | A store issues this cycle |
| st_has_info | input | 1 | The store carries footprint information |
| st_base | input | BASE_W | Store base identifier |
| st_offset | input | OFS_W | Store offset, signed |
| st_size | input | SIZE_W | Store size in bytes |
| ld_valid | input | 1 | A load query is presented |
| ld_has_info | input | 1 | The load carries footprint information |
| ld_base | input | BASE_W | Load base identifier |
| ld_offset | input | OFS_W | Load offset, signed |
| ld_size | input | SIZE_W | Load size in bytes |
| overlap_hit | output | 1 | The load overlaps a recorded store |

## Verification
A wrong fill count or a wrong state shows up at the first query that depends on the lost or extra entry. A dropped store gives a missing hit. A fifth store that is wrongly kept gives a spurious hit. A table that is not emptied by a clear keeps hitting in the next group. All of these appear in the cycle right after the faulty update. The bench places loads exactly at the inclusive and exclusive edge of each interval and at the extremes of the signed offset range. A comparator that is off by one, a compare done as unsigned, or a sum that wraps therefore flips `overlap_hit` on a single query.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    // Fill level of the per-group store table
    typedef enum logic [1:0] {
        TBL_EMPTY   = 2'd0,
        TBL_FILLING = 2'd1,
        TBL_FULL    = 2'd2
    } tbl_state_e;

endpackage

// File: rtl/ovl_range_cmp.sv
module ovl_range_cmp #(
    parameter int BASE_W = 8,
    parameter int OFS_W  = 64,
    parameter int SIZE_W = 16
) (
    input  logic              e_valid,
    input  logic [BASE_W-1:0] e_base,
    input  logic [OFS_W-1:0]  e_offset,
    input  logic [SIZE_W-1:0] e_size,
    input  logic [BASE_W-1:0] q_base,
    input  logic [OFS_W-1:0]  q_offset,
    input  logic [SIZE_W-1:0] q_size,
    output logic              hit
);
    localparam int EXT_W = OFS_W + 1;

    logic signed [EXT_W-1:0] e_off_x, q_off_x, e_end_x, q_end_x;
    logic same_base, same_off, store_below;

    always_comb begin
        e_off_x = signed'({e_offset[OFS_W-1], e_offset});
        q_off_x = signed'({q_offset[OFS_W-1], q_offset});
        e_end_x = e_off_x + signed'({{(EXT_W-SIZE_W){1'b0}}, e_size});
        q_end_x = q_off_x + signed'({{(EXT_W-SIZE_W){1'b0}}, q_size});
        same_base   = (e_base == q_base);
        same_off    = (e_offset == q_offset);
        store_below = (e_off_x < q_off_x);
        hit = 1'b0;
        if (e_valid && same_base) begin
            if (same_off)
                hit = 1'b1;
            else if (store_below)
                hit = (e_end_x > q_off_x);
            else
                hit = (q_end_x > e_off_x);
        end
    end

endmodule

// File: rtl/ovl_store_table.sv
module ovl_store_table
    import ovl_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int BASE_W = 8,
    parameter int OFS_W  = 64,
    parameter int SIZE_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          st_valid,
    input  logic                          st_has_info,
    input  logic [BASE_W-1:0]             st_base,
    input  logic [OFS_W-1:0]              st_offset,
    input  logic [SIZE_W-1:0]             st_size,
    output logic [DEPTH-1:0]              ent_valid,
    output logic [DEPTH-1:0][BASE_W-1:0]  ent_base,
    output logic [DEPTH-1:0][OFS_W-1:0]   ent_offset,
    output logic [DEPTH-1:0][SIZE_W-1:0]  ent_size,
    output logic [CNT_W-1:0]              ent_count
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(DEPTH - 1);

    tbl_state_e       state_q, state_d, state_eff;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_eff;
    logic             rec;

    // Next state: a clear acts first, then a store may be recorded
    always_comb begin
        state_eff = clr ? TBL_EMPTY : state_q;
        cnt_eff   = clr ? '0 : cnt_q;
        rec       = st_valid && st_has_info && (state_eff != TBL_FULL);
        state_d   = state_eff;
        cnt_d     = cnt_eff;
        unique case (state_eff)
            TBL_EMPTY: begin
                if (rec) begin
                    state_d = (DEPTH == 1) ? TBL_FULL : TBL_FILLING;
                    cnt_d   = CNT_W'(1);
                end
            end
            TBL_FILLING: begin
                if (rec) begin
                    cnt_d   = cnt_eff + CNT_W'(1);
                    state_d = (cnt_eff == LAST_C) ? TBL_FULL : TBL_FILLING;
                end
            end
            TBL_FULL: begin
                state_d = TBL_FULL;
            end
            default: begin
                state_d = TBL_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TBL_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Entry storage, written at the slot the fill count points to
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_base[i]   <= '0;
                ent_offset[i] <= '0;
                ent_size[i]   <= '0;
            end else if (rec && (cnt_eff == CNT_W'(i))) begin
                ent_base[i]   <= st_base;
                ent_offset[i] <= st_offset;
                ent_size[i]   <= st_size;
            end
        end
    end

    // Outputs
    always_comb begin
        ent_count = cnt_q;
        for (int i = 0; i < DEPTH; i++)
            ent_valid[i] = (CNT_W'(i) < cnt_q);
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);
    a_r1_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TBL_FULL && !clr) |=> (state_q == TBL_FULL && cnt_q == DEPTH_C));
    a_r2_no_info_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_has_info && !clr) |=> $stable(cnt_q));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !st_valid) |=> (cnt_q == '0 && state_q == TBL_EMPTY));
    a_r9_clear_then_store: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && st_valid && st_has_info) |=> (cnt_q == CNT_W'(1)));
    a_r1_empty_state_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TBL_EMPTY) |-> (cnt_q == '0));

endmodule

// File: rtl/grp_mem_overlap.sv
module grp_mem_overlap #(
    parameter int DEPTH  = 4,
    parameter int BASE_W = 8,
    parameter int OFS_W  = 64,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_clear,
    input  logic              st_valid,
    input  logic              st_has_info,
    input  logic [BASE_W-1:0] st_base,
    input  logic [OFS_W-1:0]  st_offset,
    input  logic [SIZE_W-1:0] st_size,
    input  logic              ld_valid,
    input  logic              ld_has_info,
    input  logic [BASE_W-1:0] ld_base,
    input  logic [OFS_W-1:0]  ld_offset,
    input  logic [SIZE_W-1:0] ld_size,
    output logic              overlap_hit
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]             ent_valid;
    logic [DEPTH-1:0][BASE_W-1:0] ent_base;
    logic [DEPTH-1:0][OFS_W-1:0]  ent_offset;
    logic [DEPTH-1:0][SIZE_W-1:0] ent_size;
    logic [CNT_W-1:0]             ent_count;
    logic [DEPTH-1:0]             slot_hit;

    ovl_store_table #(
        .DEPTH(DEPTH), .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (grp_clear),
        .st_valid   (st_valid),
        .st_has_info(st_has_info),
        .st_base    (st_base),
        .st_offset  (st_offset),
        .st_size    (st_size),
        .ent_valid  (ent_valid),
        .ent_base   (ent_base),
        .ent_offset (ent_offset),
        .ent_size   (ent_size),
        .ent_count  (ent_count)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        ovl_range_cmp #(
            .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
        ) u_cmp (
            .e_valid (ent_valid[i]),
            .e_base  (ent_base[i]),
            .e_offset(ent_offset[i]),
            .e_size  (ent_size[i]),
            .q_base  (ld_base),
            .q_offset(ld_offset),
            .q_size  (ld_size),
            .hit     (slot_hit[i])
        );
    end

    always_comb begin
        overlap_hit = ld_valid && ld_has_info && (ent_count != '0) && (|slot_hit);
    end

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_count == '0) |-> !overlap_hit);
    a_r7_gated_query: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid || !ld_has_info) |-> !overlap_hit);
    a_r8_next_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_clear && !st_valid) |=> !overlap_hit);

endmodule

// File: tb/grp_mem_overlap_tb.sv
module grp_mem_overlap_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [7:0]  base;
        logic [63:0] off;
        logic [15:0] size;
        logic        info;
        logic        exp;
        logic [7:0]  req;
    } qvec_t;

    // Stores preloaded: base1 off100 sz8, base1 off-16 sz4, base2 off0 sz16
    localparam int NVEC = 12;
    localparam qvec_t VECS [NVEC] = '{
        '{8'd1, 64'd100,  16'd0, 1'b1, 1'b1, 8'd3},  // R3 exact
        '{8'd1, 64'd107,  16'd1, 1'b1, 1'b1, 8'd4},  // R4 last byte
        '{8'd1, 64'd108,  16'd4, 1'b1, 1'b0, 8'd4},  // R4 just past
        '{8'd1, 64'd96,   16'd4, 1'b1, 1'b0, 8'd5},  // R5 touching
        '{8'd1, 64'd96,   16'd5, 1'b1, 1'b1, 8'd5},  // R5 one byte in
        '{8'd1, -64'sd20, 16'd5, 1'b1, 1'b1, 8'd5},  // R5 negative
        '{8'd1, -64'sd13, 16'd2, 1'b1, 1'b1, 8'd4},  // R4 negative
        '{8'd1, -64'sd12, 16'd8, 1'b1, 1'b0, 8'd4},  // R4 past end
        '{8'd3, 64'd100,  16'd8, 1'b1, 1'b0, 8'd6},  // R6 other base
        '{8'd2, 64'd8,    16'd1, 1'b1, 1'b1, 8'd4},  // R4 base 2
        '{8'd1, 64'd100,  16'd8, 1'b0, 1'b0, 8'd7},  // R7 no info
        '{8'd2, 64'd16,   16'd4, 1'b1, 1'b0, 8'd4}   // R4 end of base 2
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        grp_clear, st_valid, st_has_info, ld_valid, ld_has_info;
    logic [7:0]  st_base, ld_base;
    logic [63:0] st_offset, ld_offset;
    logic [15:0] st_size, ld_size;
    logic        overlap_hit;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_mem_overlap u_dut (
        .clk(clk), .rst_n(rst_n), .grp_clear(grp_clear),
        .st_valid(st_valid), .st_has_info(st_has_info),
        .st_base(st_base), .st_offset(st_offset), .st_size(st_size),
        .ld_valid(ld_valid), .ld_has_info(ld_has_info),
        .ld_base(ld_base), .ld_offset(ld_offset), .ld_size(ld_size),
        .overlap_hit(overlap_hit)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s overlap_hit got=%0b expected=%0b", req, got, exp);
        end
    endtask

    // Drive one store over one clock edge, starting and ending on a falling edge
    task automatic store(input logic [7:0] b, input logic [63:0] o,
                         input logic [15:0] s, input logic info, input logic clr);
        st_valid = 1'b1; st_has_info = info; st_base = b; st_offset = o;
        st_size = s; grp_clear = clr;
        @(negedge clk);
        st_valid = 1'b0; grp_clear = 1'b0;
    endtask

    task automatic clear_group();
        grp_clear = 1'b1;
        @(negedge clk);
        grp_clear = 1'b0;
    endtask

    // Combinational query, sampled mid-low-phase
    task automatic query(input string req, input logic [7:0] b, input logic [63:0] o,
                         input logic [15:0] s, input logic info, input logic exp);
        ld_valid = 1'b1; ld_has_info = info; ld_base = b; ld_offset = o; ld_size = s;
        #1;
        check(req, overlap_hit, exp);
        ld_valid = 1'b0;
        #1;
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; grp_clear = 1'b0; st_valid = 1'b0; st_has_info = 1'b0;
        st_base = '0; st_offset = '0; st_size = '0;
        ld_valid = 1'b0; ld_has_info = 1'b0; ld_base = '0; ld_offset = '0; ld_size = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: table empty, R7
        query("R7", 8'd0, 64'd0, 16'd8, 1'b1, 1'b0);

        store(8'd1, 64'd100, 16'd8, 1'b1, 1'b0);
        store(8'd1, -64'sd16, 16'd4, 1'b1, 1'b0);
        store(8'd2, 64'd0, 16'd16, 1'b1, 1'b0);

        for (int i = 0; i < NVEC; i++)
            query($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].base, VECS[i].off,
                  VECS[i].size, VECS[i].info, VECS[i].exp);

        // R7: ld_valid low with matching footprint
        ld_has_info = 1'b1; ld_base = 8'd1; ld_offset = 64'd100; ld_size = 16'd8;
        ld_valid = 1'b0;
        #1 check("R7 no valid", overlap_hit, 1'b0);

        // R8: clear ends group
        clear_group();
        query("R8", 8'd1, 64'd100, 16'd8, 1'b1, 1'b0);

        // R2: store without info not kept
        store(8'd5, 64'd0, 16'd8, 1'b0, 1'b0);
        query("R2", 8'd5, 64'd0, 16'd8, 1'b1, 1'b0);

        // R1: fifth store dropped
        clear_group();
        for (int k = 0; k < 5; k++)
            store(8'd7, 64'(k * 10), 16'd4, 1'b1, 1'b0);
        query("R1 fourth kept", 8'd7, 64'd30, 16'd4, 1'b1, 1'b1);
        query("R1 fifth dropped", 8'd7, 64'd40, 16'd4, 1'b1, 1'b0);

        // R10: same-cycle store not visible, visible next cycle
        clear_group();
        st_valid = 1'b1; st_has_info = 1'b1; st_base = 8'd9; st_offset = 64'd0; st_size = 16'd4;
        query("R10 same cycle", 8'd9, 64'd0, 16'd4, 1'b1, 1'b0);
        @(negedge clk);
        st_valid = 1'b0;
        query("R10 next cycle", 8'd9, 64'd0, 16'd4, 1'b1, 1'b1);

        // R9: store with clear becomes sole entry
        store(8'd10, 64'd0, 16'd4, 1'b1, 1'b1);
        query("R9 old gone", 8'd9, 64'd0, 16'd4, 1'b1, 1'b0);
        query("R9 new kept", 8'd10, 64'd2, 16'd1, 1'b1, 1'b1);

        // R11: extremes of the offset range
        clear_group();
        store(8'd11, 64'h7FFF_FFFF_FFFF_FFF0, 16'hFFFF, 1'b1, 1'b0);
        query("R11 no wrap", 8'd11, 64'h7FFF_FFFF_FFFF_FFFF, 16'd1, 1'b1, 1'b1);
        query("R11 signed", 8'd11, 64'h8000_0000_0000_0000, 16'hFFFF, 1'b1, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule